// File: doc/BRIEF.md
# Cache Control Invalidate Sequencer

This block empties an instruction cache or a data cache through a shared 16-bit control register. That register holds an enable, an invalidate and a busy flag for each cache. A one-cycle request on `start_i` picks the target cache with `sel_i`. The sequencer first reads the register. If the target cache is enabled, the sequencer runs a fixed handshake and then pulses `done_o`. If the target cache is disabled, it skips the handshake and pulses `done_o`.

The handshake has five steps, in this order:
1. Turn the cache off.
2. Poll until its busy flag reads zero.
3. Raise its invalidate flag.
4. Poll until busy reads zero again.
5. Write the enable back on with invalidate cleared, in one write, then read the register once.

While the register writes and the read-back take place, the interrupt-mask output is held high. Once the sequence ends, it follows the incoming mask again.

The top also holds a model of the cache core:
- It holds the control register.
- It raises a busy flag for a set number of cycles when a cache is turned off, or when invalidate is raised.
- It flash-clears the per-line valid bits of a cache when its invalidate flag rises.
- A host write port loads the register.
- A fill port marks single lines valid.

Sequencer states:
- `ST_IDLE`: waits for a request.
- `ST_PROBE`: reads the register. Goes to `ST_DISABLE` if the cache is on, otherwise to `ST_FINISH`.
- `ST_DISABLE`: writes the enable off. Goes to `ST_DRAIN_OFF`.
- `ST_DRAIN_OFF`: polls busy. Goes to `ST_INVAL` when busy is clear.
- `ST_INVAL`: writes invalidate on. Goes to `ST_DRAIN_INV`.
- `ST_DRAIN_INV`: polls busy. Goes to `ST_ENABLE` when busy is clear.
- `ST_ENABLE`: writes the final value. Goes to `ST_CONFIRM`.
- `ST_CONFIRM`: performs the one read-back. Goes to `ST_FINISH`.
- `ST_FINISH`: pulses done. Goes to `ST_IDLE`.

Top module: `cinv_top`

## Requirements
- R1: Control register layout (`ctl_o`):
  - Bit 0 enables the instruction cache and bit 1 enables the data cache.
  - Bit 4 is instruction-cache invalidate and bit 5 is data-cache invalidate.
  - Bit 8 is instruction-cache busy and bit 9 is data-cache busy. Both busy bits are read-only, and writes to them are ignored.
  - `sel_i`=0 targets the instruction cache and `sel_i`=1 targets the data cache.
- R2: If the target enable bit reads 0 in `ST_PROBE`, then `done_o` pulses on the second edge after the start edge. No register write is issued, and `irq_mask_o` is not forced.
- R3: The first write equals the probed register value, non-busy bits only, with just the target enable bit cleared.
- R4: After each of the first two writes, the register is read every cycle until the target busy bit is 0. The second write is the first write with the target invalidate bit set.
- R5: The third write equals the probed value with the target enable set and target invalidate cleared. It is followed by exactly one read before `done_o`.
- R6: `irq_mask_o` is 1 in every cycle from the first write through the read-back. In all other cycles it equals `irq_mask_i`.
- R7: Every sequencer write leaves the other cache's enable and invalidate bits equal to their current register values.
- R8: `busy_o` is 1 from the edge after an accepted start through the cycle in which `done_o` is high, and 0 after that. `done_o` lasts one cycle.
- R9: A start pulse while `busy_o` is 1 is ignored. It changes neither the latency nor the writes, and it starts no second sequence.
- R10: In the core model, clearing an enable bit holds that cache's busy for `DRAIN_CYC` cycles. Raising an invalidate bit clears all of that cache's valid bits and holds busy for `FLUSH_CYC` cycles. A full sequence therefore takes `DRAIN_CYC+FLUSH_CYC+8` edges from the start edge to the first `done_o` sample.
- R11: A host write loads the non-busy bits of the register. A fill sets one valid bit of the chosen cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Invalidate request pulse |
| sel_i | input | 1 | Target cache: 0 instruction, 1 data |
| irq_mask_i | input | 1 | Interrupt mask requested by the rest of the system |
| cfg_we_i | input | 1 | Host write strobe for the control register |
| cfg_wdata_i | input | 16 | Host write data |
| fill_en_i | input | 1 | Mark one line valid |
| fill_sel_i | input | 1 | Cache of the fill |
| fill_idx_i | input | IDX_W | Line index of the fill |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| irq_mask_o | output | 1 | Effective interrupt mask |
| ctl_o | output | 16 | Current control register value, busy bits included |
| reg_wr_o | output | 1 | Sequencer register write strobe |
| reg_rd_o | output | 1 | Sequencer register read strobe |
| reg_wdata_o | output | 16 | Sequencer write data |
| ic_valid_o | output | NLINES | Instruction-cache line valid bits |
| dc_valid_o | output | NLINES | Data-cache line valid bits |

## Verification
The assertions assume three things about the inputs:
- The host write port and the fill port are used only while `busy_o` is low.
- A host write never lands in the same cycle as a sequencer write.
- The other cache's control bits do not change while a sequence runs.

The stimulus respects these limits. Host writes and fills happen only between sequences, followed by enough idle cycles for any busy period they start to expire. Randomised configurations always leave the invalidate bits clear, so every enabled sequence produces a real flash-clear. Requests made during a sequence arrive only through `start_i`.

// File: rtl/cinv_pkg.sv
package cinv_pkg;

    localparam int CTL_W     = 16;
    localparam int NCACHE    = 2;
    localparam int EN_BASE   = 0;
    localparam int INV_BASE  = 4;
    localparam int BUSY_BASE = 8;

    typedef logic [CTL_W-1:0] ctl_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROBE,
        ST_DISABLE,
        ST_DRAIN_OFF,
        ST_INVAL,
        ST_DRAIN_INV,
        ST_ENABLE,
        ST_CONFIRM,
        ST_FINISH
    } seq_state_e;

    localparam ctl_t BUSY_MASK = ctl_t'(((1 << NCACHE) - 1) << BUSY_BASE);

    function automatic ctl_t en_bit(input logic sel);
        return ctl_t'(1) << (EN_BASE + int'(sel));
    endfunction

    function automatic ctl_t inv_bit(input logic sel);
        return ctl_t'(1) << (INV_BASE + int'(sel));
    endfunction

    function automatic ctl_t busy_bit(input logic sel);
        return ctl_t'(1) << (BUSY_BASE + int'(sel));
    endfunction

endpackage

// File: rtl/cinv_seq.sv
module cinv_seq
    import cinv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sel_i,
    input  logic irq_mask_i,
    input  ctl_t rd_data_i,
    output logic rd_en_o,
    output logic wr_en_o,
    output ctl_t wr_data_o,
    output logic busy_o,
    output logic done_o,
    output logic irq_mask_o
);

    seq_state_e st_q, st_d;
    ctl_t       shadow_q, shadow_d;
    logic       sel_q, sel_d;

    ctl_t en_m, inv_m, bsy_m;
    assign en_m  = en_bit(sel_q);
    assign inv_m = inv_bit(sel_q);
    assign bsy_m = busy_bit(sel_q);

    logic tgt_on, tgt_busy;
    assign tgt_on   = |(rd_data_i & en_m);
    assign tgt_busy = |(rd_data_i & bsy_m);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            shadow_q <= '0;
            sel_q    <= 1'b0;
        end else begin
            st_q     <= st_d;
            shadow_q <= shadow_d;
            sel_q    <= sel_d;
        end
    end

    // next state
    always_comb begin
        st_d     = st_q;
        shadow_d = shadow_q;
        sel_d    = sel_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    sel_d = sel_i;
                    st_d  = ST_PROBE;
                end
            end
            ST_PROBE: begin
                if (tgt_on) begin
                    shadow_d = rd_data_i & ~BUSY_MASK;
                    st_d     = ST_DISABLE;
                end else begin
                    st_d = ST_FINISH;
                end
            end
            ST_DISABLE: begin
                shadow_d = shadow_q & ~en_m;
                st_d     = ST_DRAIN_OFF;
            end
            ST_DRAIN_OFF: begin
                if (!tgt_busy) st_d = ST_INVAL;
            end
            ST_INVAL: begin
                shadow_d = shadow_q | inv_m;
                st_d     = ST_DRAIN_INV;
            end
            ST_DRAIN_INV: begin
                if (!tgt_busy) st_d = ST_ENABLE;
            end
            ST_ENABLE: st_d = ST_CONFIRM;
            ST_CONFIRM: st_d = ST_FINISH;
            ST_FINISH: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_en_o   = 1'b0;
        wr_en_o   = 1'b0;
        wr_data_o = '0;
        done_o    = 1'b0;
        busy_o    = (st_q != ST_IDLE);
        unique case (st_q)
            ST_PROBE, ST_DRAIN_OFF, ST_DRAIN_INV, ST_CONFIRM: rd_en_o = 1'b1;
            ST_DISABLE: begin
                wr_en_o   = 1'b1;
                wr_data_o = shadow_q & ~en_m;
            end
            ST_INVAL: begin
                wr_en_o   = 1'b1;
                wr_data_o = shadow_q | inv_m;
            end
            ST_ENABLE: begin
                wr_en_o   = 1'b1;
                wr_data_o = (shadow_q & ~inv_m) | en_m;
            end
            ST_FINISH: done_o = 1'b1;
            default: ;
        endcase
    end

    logic masking;
    always_comb begin
        unique case (st_q)
            ST_DISABLE, ST_DRAIN_OFF, ST_INVAL,
            ST_DRAIN_INV, ST_ENABLE, ST_CONFIRM: masking = 1'b1;
            default: masking = 1'b0;
        endcase
    end
    assign irq_mask_o = masking | irq_mask_i;

endmodule

// File: rtl/cinv_core.sv
module cinv_core
    import cinv_pkg::*;
#(
    parameter int NLINES    = 16,
    parameter int DRAIN_CYC = 3,
    parameter int FLUSH_CYC = 5,
    localparam int IDX_W    = $clog2(NLINES),
    localparam int CNT_MAX  = (DRAIN_CYC > FLUSH_CYC) ? DRAIN_CYC : FLUSH_CYC,
    localparam int CNT_W    = $clog2(CNT_MAX + 2)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  ctl_t                     wr_data_i,
    output ctl_t                     rd_data_o,
    input  logic                     fill_en_i,
    input  logic                     fill_sel_i,
    input  logic [IDX_W-1:0]         fill_idx_i,
    output logic [NCACHE*NLINES-1:0] valid_o
);

    ctl_t              ctl_q;
    logic [NCACHE-1:0] busy_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctl_q <= '0;
        else if (wr_en_i) ctl_q <= wr_data_i & ~BUSY_MASK;
    end

    for (genvar c = 0; c < NCACHE; c++) begin : g_cache
        logic [CNT_W-1:0]  cnt_q;
        logic [NLINES-1:0] vld_q;
        logic              turn_off, inv_rise;

        assign turn_off = wr_en_i && ctl_q[EN_BASE + c] && !wr_data_i[EN_BASE + c];
        assign inv_rise = wr_en_i && !ctl_q[INV_BASE + c] && wr_data_i[INV_BASE + c];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (inv_rise)       cnt_q <= CNT_W'(FLUSH_CYC);
            else if (turn_off)       cnt_q <= CNT_W'(DRAIN_CYC);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              vld_q <= '0;
            else if (inv_rise)                       vld_q <= '0;
            else if (fill_en_i && (fill_sel_i == c)) vld_q[fill_idx_i] <= 1'b1;
        end

        assign busy_vec[c]                   = (cnt_q != '0);
        assign valid_o[c*NLINES +: NLINES]   = vld_q;
    end

    always_comb begin
        rd_data_o = ctl_q;
        for (int c = 0; c < NCACHE; c++) begin
            rd_data_o[BUSY_BASE + c] = busy_vec[c];
        end
    end

endmodule

// File: rtl/cinv_top.sv
module cinv_top
    import cinv_pkg::*;
#(
    parameter int NLINES    = 16,
    parameter int DRAIN_CYC = 3,
    parameter int FLUSH_CYC = 5,
    localparam int IDX_W    = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sel_i,
    input  logic              irq_mask_i,
    input  logic              cfg_we_i,
    input  logic [15:0]       cfg_wdata_i,
    input  logic              fill_en_i,
    input  logic              fill_sel_i,
    input  logic [IDX_W-1:0]  fill_idx_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              irq_mask_o,
    output logic [15:0]       ctl_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic [15:0]       reg_wdata_o,
    output logic [NLINES-1:0] ic_valid_o,
    output logic [NLINES-1:0] dc_valid_o
);

    ctl_t                     rd_data, seq_wdata, core_wdata;
    logic                     seq_wr, seq_rd, core_wr;
    logic [NCACHE*NLINES-1:0] valid_all;

    cinv_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .sel_i      (sel_i),
        .irq_mask_i (irq_mask_i),
        .rd_data_i  (rd_data),
        .rd_en_o    (seq_rd),
        .wr_en_o    (seq_wr),
        .wr_data_o  (seq_wdata),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .irq_mask_o (irq_mask_o)
    );

    // sequencer writes take precedence over host writes
    assign core_wr    = seq_wr | cfg_we_i;
    assign core_wdata = seq_wr ? seq_wdata : cfg_wdata_i;

    cinv_core #(
        .NLINES    (NLINES),
        .DRAIN_CYC (DRAIN_CYC),
        .FLUSH_CYC (FLUSH_CYC)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (core_wr),
        .wr_data_i  (core_wdata),
        .rd_data_o  (rd_data),
        .fill_en_i  (fill_en_i),
        .fill_sel_i (fill_sel_i),
        .fill_idx_i (fill_idx_i),
        .valid_o    (valid_all)
    );

    assign ctl_o       = rd_data;
    assign reg_wr_o    = seq_wr;
    assign reg_rd_o    = seq_rd;
    assign reg_wdata_o = seq_wdata;
    assign ic_valid_o  = valid_all[0 +: NLINES];
    assign dc_valid_o  = valid_all[NLINES +: NLINES];

endmodule

// File: rtl/cinv_top_chk.sv
module cinv_top_chk
    import cinv_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        busy_o,
    input logic        done_o,
    input logic        irq_mask_o,
    input logic        reg_wr_o,
    input logic        reg_rd_o,
    input logic [15:0] reg_wdata_o,
    input logic [15:0] ctl_o,
    input logic        sel_q
);

    ctl_t other_m;
    assign other_m = en_bit(!sel_q) | inv_bit(!sel_q);

    a_r6_mask_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> irq_mask_o);

    a_r7_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> ((reg_wdata_o & other_m) == (ctl_o & other_m)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    a_r5_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_o && reg_rd_o));

endmodule

bind cinv_top cinv_top_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .irq_mask_o  (irq_mask_o),
    .reg_wr_o    (reg_wr_o),
    .reg_rd_o    (reg_rd_o),
    .reg_wdata_o (reg_wdata_o),
    .ctl_o       (ctl_o),
    .sel_q       (u_seq.sel_q)
);

// File: tb/cinv_top_tb.sv
`timescale 1ns/1ps
module cinv_top_tb;

    localparam int NLINES = 16;
    localparam int DRAIN  = 3;
    localparam int FLUSH  = 5;
    localparam logic [15:0] BUSYM = 16'h0300;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0, sel_i = 1'b0, irq_mask_i = 1'b0;
    logic              cfg_we_i = 1'b0;
    logic [15:0]       cfg_wdata_i = '0;
    logic              fill_en_i = 1'b0, fill_sel_i = 1'b0;
    logic [3:0]        fill_idx_i = '0;
    logic              busy_o, done_o, irq_mask_o, reg_wr_o, reg_rd_o;
    logic [15:0]       ctl_o, reg_wdata_o;
    logic [NLINES-1:0] ic_valid_o, dc_valid_o;

    always #5 clk = ~clk;

    cinv_top #(.NLINES(NLINES), .DRAIN_CYC(DRAIN), .FLUSH_CYC(FLUSH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
        .irq_mask_i(irq_mask_i), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .fill_en_i(fill_en_i), .fill_sel_i(fill_sel_i), .fill_idx_i(fill_idx_i),
        .busy_o(busy_o), .done_o(done_o), .irq_mask_o(irq_mask_o), .ctl_o(ctl_o),
        .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o), .reg_wdata_o(reg_wdata_o),
        .ic_valid_o(ic_valid_o), .dc_valid_o(dc_valid_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0]       ctl_m;
    logic [NLINES-1:0] vm [2];

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] enm(input logic s);
        return 16'h0001 << s;
    endfunction
    function automatic logic [15:0] invm(input logic s);
        return 16'h0010 << s;
    endfunction

    task automatic host_write(input logic [15:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
        for (int k = 0; k < 8; k++) @(negedge clk);
        if (((ctl_m & invm(0)) == 0) && ((d & invm(0)) != 0)) vm[0] = '0;
        if (((ctl_m & invm(1)) == 0) && ((d & invm(1)) != 0)) vm[1] = '0;
        ctl_m = d & ~BUSYM;
    endtask

    task automatic fill(input logic s, input logic [3:0] idx);
        @(negedge clk);
        fill_en_i = 1'b1; fill_sel_i = s; fill_idx_i = idx;
        @(negedge clk);
        fill_en_i = 1'b0;
        vm[s][idx] = 1'b1;
    endtask

    task automatic run_seq(input logic s, input logic m, input logic inject);
        logic [15:0] w [3];
        int          n, nw, rd_after;
        logic        mask_bad, busy_bad, mask_seen, on;
        logic [15:0] orig, e0, e1, e2;
        on = (ctl_m & enm(s)) != 0;
        orig = ctl_m;
        n = 0; nw = 0; rd_after = 0; mask_bad = 0; busy_bad = 0; mask_seen = 0;
        w[0] = '0; w[1] = '0; w[2] = '0;
        @(negedge clk);
        start_i = 1'b1; sel_i = s; irq_mask_i = m;
        while (n < 400) begin
            @(posedge clk);
            #1;
            n++;
            if (n == 1) start_i = 1'b0;
            if (inject && n == 4) begin start_i = 1'b1; sel_i = ~s; end
            if (inject && n == 5) start_i = 1'b0;
            if (!busy_o) busy_bad = 1'b1;
            if (irq_mask_o && !m) mask_seen = 1'b1;
            if (reg_wr_o) begin
                if (!irq_mask_o) mask_bad = 1'b1;
                if (nw < 3) w[nw] = reg_wdata_o;
                nw++;
            end
            if (reg_rd_o && nw >= 3) rd_after++;
            if (done_o) break;
        end
        // R8: busy throughout, done reached
        chk(!busy_bad && done_o, "R8 busy during sequence", int'(busy_bad), 0);
        if (!on) begin
            // R2: skip path
            chk(n == 2, "R2 skip latency", n, 2);
            chk(nw == 0, "R2 no write", nw, 0);
            chk(!mask_seen, "R2 mask untouched", int'(mask_seen), 0);
        end else begin
            e0 = orig & ~enm(s);
            e1 = e0 | invm(s);
            e2 = (e1 & ~invm(s)) | enm(s);
            // R10 / R9: latency independent of injected start
            chk(n == DRAIN + FLUSH + 8, inject ? "R9 latency with ignored start" : "R10 latency",
                n, DRAIN + FLUSH + 8);
            chk(nw == 3, "R5 write count", nw, 3);
            chk(w[0] == e0, "R3 first write", w[0], e0);
            chk(w[1] == e1, "R4 second write", w[1], e1);
            chk(w[2] == e2, "R5 third write", w[2], e2);
            chk(rd_after == 1, "R5 single read-back", rd_after, 1);
            chk(!mask_bad, "R6 mask during writes", int'(mask_bad), 0);
            vm[s] = '0;
        end
        @(posedge clk);
        #1;
        chk(!busy_o && !done_o, inject ? "R9 no second sequence" : "R8 busy low after done",
            int'({busy_o, done_o}), 0);
        chk(irq_mask_o == m, "R6 mask restored", int'(irq_mask_o), int'(m));
        chk((ctl_o & ~BUSYM) == ctl_m, "R7 register after sequence", ctl_o & ~BUSYM, ctl_m);
        chk(ic_valid_o == vm[0] && dc_valid_o == vm[1], "R10 valid bits",
            {ic_valid_o, dc_valid_o}, {vm[0], vm[1]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        ctl_m = '0; vm[0] = '0; vm[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl_o == 16'h0 && !busy_o && !done_o && !reg_wr_o, "R8 reset state", ctl_o, 0);
        chk(ic_valid_o == '0 && dc_valid_o == '0, "R10 reset valid", ic_valid_o, 0);

        // R11 / R1: busy bits not writable, fills visible
        fill(1'b0, 4'd3);
        fill(1'b1, 4'd9);
        chk(ic_valid_o == vm[0] && dc_valid_o == vm[1], "R11 fill", dc_valid_o, vm[1]);
        host_write(16'hFFFF);
        chk(ctl_o == 16'hFCFF, "R1 busy bits read-only", ctl_o, 16'hFCFF);
        chk(ic_valid_o == '0 && dc_valid_o == '0, "R10 host invalidate clears", ic_valid_o, 0);

        // R2: disabled targets
        host_write(16'hA000);
        run_seq(1'b0, 1'b0, 1'b0);
        host_write(16'hA001);
        fill(1'b1, 4'd1);
        run_seq(1'b1, 1'b1, 1'b0);

        // enabled, directed
        fill(1'b0, 4'd15);
        run_seq(1'b0, 1'b0, 1'b0);
        host_write(16'h5003);
        fill(1'b1, 4'd0);
        run_seq(1'b1, 1'b0, 1'b1);

        for (int i = 0; i < 30; i++) begin
            logic [15:0] d;
            d = 16'($urandom) & 16'hFCCF;
            host_write(d);
            for (int j = 0; j < 3; j++) fill(1'($urandom), 4'($urandom));
            run_seq(1'($urandom), 1'($urandom), (i % 5) == 0);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule